// File: doc/BRIEF.md
# Two-Domain Work-Mode Controller

This block keeps the work mode of a chip built from two power domains: a safety domain, which owns core 0, and an application domain, which owns cores 1 to 4. Each domain leaves RUN for a configured low-power target when low power is enabled for it and all of its cores report WFI. It returns to RUN when one of its enabled wakeup lines rises. At each transition the block pulses a start strobe toward the power sequencer. The sequencer answers with a done pulse, and a per-domain countdown guards the wait for that pulse.

Three policy bits set how the domains are coupled. One makes the chip mode track the safety domain alone. One pulls the application domain into low power at the moment the safety domain starts its entry. One wakes the application domain together with the safety domain. The block also reports sticky timeout and illegal-transition flags, and raises per-core wakeup and error interrupts that software clears through the same write port. Each domain's configuration may be written only by that domain's primary core.

Top module: `dom_mode_ctrl`

## Requirements
- R1: After reset the safety, application and chip modes read RUN (code 0), and all strobes, flags and interrupts are 0. Mode codes are RUN=0, SLEEP=1, HIBERNATE=2, RTC=3. A domain never reports code 3.
- R2: Entry starts when a domain's config bit 0 (low-power enable) is set and all of its cores have WFI high. In the cycle after that edge, its lpStart bit is high for exactly one cycle. The mode code stays RUN until the domain's lpDone pulse is taken. It then shows SLEEP, or HIBERNATE if config bit 1 is set.
- R3: No entry starts while low-power enable is clear or while any core of the domain lacks WFI.
- R4: In low power, a wakeup line whose bit is set in the domain's wake mask (register 2 for safety, register 3 for the application) pulses runStart for one cycle. The target code stays visible until runDone, and then the mode is RUN. A line that is not in the mask has no effect.
- R5: An enabled wakeup line during entry aborts the entry. The domain goes straight to RUN with no runStart, no interrupt and no illegal flag.
- R6: Each start strobe reloads a per-domain 16-bit counter from register 5. The counter decrements each cycle while a done is awaited. If the counter is zero and no done has come, tmoFlag sets and the domain returns to RUN. With a reload of N, the flag rises N+1 cycles after the lpStart cycle.
- R7: An lpDone outside entry, or a runDone outside exit, sets illFlag. If config bit 2 is set and the domain is in low power, the stray done also wakes the domain.
- R8: The chip mode is the smaller of the two domain codes. When register 4 bit 0 is set, it is the safety mode alone.
- R9: With register 4 bit 1 set, the application domain starts entry on the same edge as the safety domain, whatever its own enable and WFI.
- R10: With register 4 bit 2 set, the application domain also leaves low power on the same edge as the safety domain.
- R11: When a domain starts its exit, wakeIrq bits are set for that domain's cores whose bit is set in register 6 bits 4:0. Writing a 1 to bit k of register 7 clears wakeIrq bit k.
- R12: A timeout or illegal event sets errIrq for every core whose bit is set in register 6 bits 12:8. Writing to register 7 clears these bits: bits 12:8 clear errIrq, bit 14 clears tmoFlag and bit 15 clears illFlag.
- R13: Registers 1 and 3 may be written only by the application primary core (register 4 bits 9:7, reset value 1). Register 7 may be written by any core. All other registers may be written only by the safety primary core (register 4 bits 6:4, reset value 0). A write from any other core is dropped. When register 4 bit 3 is set, wrErr is high during that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wfi | input | 5 | Per-core WFI flags |
| wakeReq | input | 8 | Wakeup request lines |
| lpDone | input | 2 | Entry-complete pulse per domain (bit 0 safety) |
| runDone | input | 2 | Exit-complete pulse per domain |
| wrEn | input | 1 | Register write strobe |
| wrCore | input | 3 | Index of the writing core |
| wrAddr | input | 3 | Register index |
| wrData | input | 16 | Write data |
| wrErr | output | 1 | Rejected-write error, same cycle as wrEn |
| safeMode | output | 2 | Safety domain mode code |
| appMode | output | 2 | Application domain mode code |
| chipMode | output | 2 | Chip-level mode code |
| lpStart | output | 2 | One-cycle entry start strobe per domain |
| runStart | output | 2 | One-cycle exit start strobe per domain |
| tmoFlag | output | 1 | Sticky transition timeout flag |
| illFlag | output | 1 | Sticky illegal-transition flag |
| wakeIrq | output | 5 | Per-core wakeup interrupt |
| errIrq | output | 5 | Per-core error interrupt |

## Verification
The entry path is driven with enable off, with one application core missing WFI, and with every condition met. This shows that both gating terms are really checked. Wakeup is driven on a masked line and then an unmasked one, and also during entry, which separates a real exit from an abort. Timeouts and stray done pulses are driven with and without the illegal-wakeup enable. The domains are placed at different depths under each policy setting, which shows the shallower-mode rule, the safety-only rule and the two alignment paths apart.

// File: rtl/dmc_pkg.sv
`timescale 1ns/1ps
package dmc_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_SLEEP = 2'd1,
    MODE_HIB   = 2'd2,
    MODE_RTC   = 2'd3
  } mode_e;

  typedef enum logic [1:0] {ST_RUN, ST_ENTER, ST_LP, ST_EXIT} dstate_e;

  // per-domain configuration, lpEn at bit 0
  typedef struct packed {
    logic illWake;
    logic deep;
    logic lpEn;
  } domCfg_t;

  // control -> datapath strobes, one set per domain
  typedef struct packed {
    logic goLp;
    logic goRun;
    logic busy;
    logic tmoEv;
    logic illEv;
  } ctlStrobe_t;
endpackage

// File: rtl/dmc_dpath.sv
`timescale 1ns/1ps
module dmc_dpath
  import dmc_pkg::*;
#(
  parameter int NCORE = 5,
  parameter int NWAKE = 8,
  parameter int TMO_W = 16,
  parameter int DW    = 16,
  parameter logic [NCORE-1:0] SAFE_MASK = 5'b00001
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [$clog2(NCORE)-1:0]   wrCore,
  input  logic [2:0]                 wrAddr,
  input  logic [DW-1:0]              wrData,
  output logic                       wrErr,
  input  ctlStrobe_t [1:0]           strb,
  output domCfg_t [1:0]              cfg,
  output logic [1:0][NWAKE-1:0]      wakeMask,
  output logic [2:0]                 policy,
  output logic [1:0]                 cntZero,
  output logic                       tmoFlag,
  output logic                       illFlag,
  output logic [NCORE-1:0]           wakeIrq,
  output logic [NCORE-1:0]           errIrq
);
  localparam int CW = $clog2(NCORE);
  localparam int PRI0_LSB = 4;
  localparam int PRI1_LSB = PRI0_LSB + CW;
  localparam int ERR_LSB = 8;
  localparam logic [NCORE-1:0] APP_MASK = ~SAFE_MASK;

  logic [CW-1:0]    safePri, appPri;
  logic             permErrEn;
  logic [TMO_W-1:0] tmoVal;
  logic [NCORE-1:0] wakeEn, errEn;
  logic             ownerOk, wrAcc, clrWr;

  always_comb begin
    unique case (wrAddr)
      3'd1, 3'd3: ownerOk = (wrCore == appPri);
      3'd7:       ownerOk = 1'b1;
      default:    ownerOk = (wrCore == safePri);
    endcase
  end

  assign wrAcc = wrEn && ownerOk;
  assign wrErr = wrEn && !ownerOk && permErrEn;
  assign clrWr = wrAcc && (wrAddr == 3'd7);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg       <= '0;
      wakeMask  <= '0;
      policy    <= '0;
      permErrEn <= 1'b0;
      safePri   <= '0;
      appPri    <= CW'(1);
      tmoVal    <= '1;
      wakeEn    <= '0;
      errEn     <= '0;
    end else if (wrAcc) begin
      unique case (wrAddr)
        3'd0: cfg[0]      <= domCfg_t'(wrData[2:0]);
        3'd1: cfg[1]      <= domCfg_t'(wrData[2:0]);
        3'd2: wakeMask[0] <= wrData[NWAKE-1:0];
        3'd3: wakeMask[1] <= wrData[NWAKE-1:0];
        3'd4: begin
          policy    <= wrData[2:0];
          permErrEn <= wrData[3];
          safePri   <= wrData[PRI0_LSB +: CW];
          appPri    <= wrData[PRI1_LSB +: CW];
        end
        3'd5: tmoVal <= wrData[TMO_W-1:0];
        3'd6: begin
          wakeEn <= wrData[NCORE-1:0];
          errEn  <= wrData[ERR_LSB +: NCORE];
        end
        default: ;
      endcase
    end
  end

  // transition watchdog counters, one per domain
  for (genvar d = 0; d < 2; d++) begin : g_cnt
    logic [TMO_W-1:0] cntQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cntQ <= '0;
      else if (strb[d].goLp || strb[d].goRun) cntQ <= tmoVal;
      else if (strb[d].busy && (cntQ != '0)) cntQ <= cntQ - 1'b1;
    end
    assign cntZero[d] = (cntQ == '0);
  end

  logic             tmoSet, illSet;
  logic [NCORE-1:0] wakeSet, errSet, wakeClr, errClr;

  assign tmoSet  = strb[0].tmoEv | strb[1].tmoEv;
  assign illSet  = strb[0].illEv | strb[1].illEv;
  assign wakeSet = (({NCORE{strb[0].goRun}} & SAFE_MASK) |
                    ({NCORE{strb[1].goRun}} & APP_MASK)) & wakeEn;
  assign errSet  = (tmoSet || illSet) ? errEn : '0;
  assign wakeClr = clrWr ? wrData[NCORE-1:0] : '0;
  assign errClr  = clrWr ? wrData[ERR_LSB +: NCORE] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmoFlag <= 1'b0;
      illFlag <= 1'b0;
      wakeIrq <= '0;
      errIrq  <= '0;
    end else begin
      tmoFlag <= tmoSet | (tmoFlag & ~(clrWr & wrData[14]));
      illFlag <= illSet | (illFlag & ~(clrWr & wrData[15]));
      wakeIrq <= wakeSet | (wakeIrq & ~wakeClr);
      errIrq  <= errSet | (errIrq & ~errClr);
    end
  end

  // R6: the timeout flag holds until a clearing write
  a_r6_tmo_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (tmoFlag && !(clrWr && wrData[14])) |=> tmoFlag);

  // R11: a wake interrupt bit holds until acknowledged
  a_r11_wake_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (wakeIrq[0] && !(clrWr && wrData[0])) |=> wakeIrq[0]);

  // R13: a write from a foreign core leaves the safety configuration unchanged
  a_r13_foreign_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrAddr == 3'd0) && (wrCore != safePri)) |=> $stable(cfg[0]));
endmodule

// File: rtl/dmc_ctrl.sv
`timescale 1ns/1ps
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int NCORE = 5,
  parameter int NWAKE = 8,
  parameter logic [NCORE-1:0] SAFE_MASK = 5'b00001
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NCORE-1:0]      wfi,
  input  logic [NWAKE-1:0]      wakeReq,
  input  logic [1:0]            lpDone,
  input  logic [1:0]            runDone,
  input  domCfg_t [1:0]         cfg,
  input  logic [1:0][NWAKE-1:0] wakeMask,
  input  logic [2:0]            policy,
  input  logic [1:0]            cntZero,
  output ctlStrobe_t [1:0]      strb,
  output logic [1:0][1:0]       domMode,
  output logic [1:0]            lpStart,
  output logic [1:0]            runStart
);
  logic safeGoLp, safeGoRun;

  for (genvar d = 0; d < 2; d++) begin : g_dom
    localparam logic [NCORE-1:0] CMASK = (d == 0) ? SAFE_MASK : ~SAFE_MASK;

    dstate_e    stQ, stD;
    logic [1:0] tgtQ;
    logic allWfi, ownWake, illDone, illWk, startCond, wakeCond;
    logic goLp, goRun, tmo;

    assign allWfi  = ((wfi & CMASK) == CMASK);
    assign ownWake = |(wakeReq & wakeMask[d]);
    assign illDone = (lpDone[d] && (stQ != ST_ENTER)) ||
                     (runDone[d] && (stQ != ST_EXIT));
    assign illWk   = illDone && cfg[d].illWake && (stQ == ST_LP);

    if (d == 0) begin : g_safe
      assign startCond = cfg[0].lpEn && allWfi;
      assign wakeCond  = ownWake || illWk;
      assign safeGoLp  = goLp;
      assign safeGoRun = goRun;
    end else begin : g_app
      assign startCond = policy[1] ? safeGoLp : (cfg[1].lpEn && allWfi);
      assign wakeCond  = ownWake || illWk || (policy[2] && safeGoRun);
    end

    always_comb begin
      stD   = stQ;
      goLp  = 1'b0;
      goRun = 1'b0;
      tmo   = 1'b0;
      unique case (stQ)
        ST_RUN: if (startCond && !ownWake) begin
          stD  = ST_ENTER;
          goLp = 1'b1;
        end
        ST_ENTER: begin
          if (ownWake) stD = ST_RUN;
          else if (lpDone[d]) stD = ST_LP;
          else if (cntZero[d]) begin
            stD = ST_RUN;
            tmo = 1'b1;
          end
        end
        ST_LP: if (wakeCond) begin
          stD   = ST_EXIT;
          goRun = 1'b1;
        end
        ST_EXIT: begin
          if (runDone[d]) stD = ST_RUN;
          else if (cntZero[d]) begin
            stD = ST_RUN;
            tmo = 1'b1;
          end
        end
        default: stD = ST_RUN;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stQ         <= ST_RUN;
        tgtQ        <= MODE_RUN;
        lpStart[d]  <= 1'b0;
        runStart[d] <= 1'b0;
      end else begin
        stQ         <= stD;
        lpStart[d]  <= goLp;
        runStart[d] <= goRun;
        if (goLp) tgtQ <= cfg[d].deep ? MODE_HIB : MODE_SLEEP;
      end
    end

    assign domMode[d] = ((stQ == ST_LP) || (stQ == ST_EXIT)) ? tgtQ : MODE_RUN;
    assign strb[d] = '{goLp: goLp, goRun: goRun,
                       busy: (stQ == ST_ENTER) || (stQ == ST_EXIT),
                       tmoEv: tmo, illEv: illDone};

    // R1: a domain never reports the RTC code
    a_r1_no_rtc: assert property (@(posedge clk) disable iff (!rstN)
      domMode[d] != MODE_RTC);

    // R2: leaving RUN for a low-power code needs an accepted entry done
    a_r2_mode_needs_done: assert property (@(posedge clk) disable iff (!rstN)
      ((domMode[d] != MODE_RUN) && ($past(domMode[d]) == MODE_RUN)) |-> $past(lpDone[d]));

    // R4: an exit strobe is only seen while a low-power code is shown
    a_r4_exit_from_lp: assert property (@(posedge clk) disable iff (!rstN)
      runStart[d] |-> (domMode[d] != MODE_RUN));
  end

  // R3: safety entry strobe needs every safety core in WFI on the edge before
  a_r3_safe_needs_wfi: assert property (@(posedge clk) disable iff (!rstN)
    lpStart[0] |-> $past(((wfi & SAFE_MASK) == SAFE_MASK) && cfg[0].lpEn));
endmodule

// File: rtl/dom_mode_ctrl.sv
`timescale 1ns/1ps
module dom_mode_ctrl
  import dmc_pkg::*;
#(
  parameter int NCORE = 5,
  parameter int NWAKE = 8,
  parameter int TMO_W = 16,
  parameter logic [NCORE-1:0] SAFE_MASK = 5'b00001
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NCORE-1:0]         wfi,
  input  logic [NWAKE-1:0]         wakeReq,
  input  logic [1:0]               lpDone,
  input  logic [1:0]               runDone,
  input  logic                     wrEn,
  input  logic [$clog2(NCORE)-1:0] wrCore,
  input  logic [2:0]               wrAddr,
  input  logic [15:0]              wrData,
  output logic                     wrErr,
  output logic [1:0]               safeMode,
  output logic [1:0]               appMode,
  output logic [1:0]               chipMode,
  output logic [1:0]               lpStart,
  output logic [1:0]               runStart,
  output logic                     tmoFlag,
  output logic                     illFlag,
  output logic [NCORE-1:0]         wakeIrq,
  output logic [NCORE-1:0]         errIrq
);
  ctlStrobe_t [1:0]      strb;
  domCfg_t [1:0]         cfg;
  logic [1:0][NWAKE-1:0] wakeMask;
  logic [2:0]            policy;
  logic [1:0]            cntZero;
  logic [1:0][1:0]       domMode;

  dmc_ctrl #(.NCORE(NCORE), .NWAKE(NWAKE), .SAFE_MASK(SAFE_MASK)) u_ctrl (
    .clk(clk), .rstN(rstN), .wfi(wfi), .wakeReq(wakeReq),
    .lpDone(lpDone), .runDone(runDone), .cfg(cfg), .wakeMask(wakeMask),
    .policy(policy), .cntZero(cntZero), .strb(strb), .domMode(domMode),
    .lpStart(lpStart), .runStart(runStart)
  );

  dmc_dpath #(.NCORE(NCORE), .NWAKE(NWAKE), .TMO_W(TMO_W), .DW(16),
              .SAFE_MASK(SAFE_MASK)) u_dpath (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrCore(wrCore), .wrAddr(wrAddr),
    .wrData(wrData), .wrErr(wrErr), .strb(strb), .cfg(cfg),
    .wakeMask(wakeMask), .policy(policy), .cntZero(cntZero),
    .tmoFlag(tmoFlag), .illFlag(illFlag), .wakeIrq(wakeIrq), .errIrq(errIrq)
  );

  assign safeMode = domMode[0];
  assign appMode  = domMode[1];
  // R8: shallower of the two, or safety alone under the ignore policy
  assign chipMode = policy[0] ? domMode[0] :
                    ((domMode[0] < domMode[1]) ? domMode[0] : domMode[1]);
endmodule

// File: tb/sim_dom_mode_ctrl.sv
`timescale 1ns/1ps
module sim_dom_mode_ctrl;
  logic clk = 1'b0;
  logic rstN;
  logic [4:0] wfi;
  logic [7:0] wakeReq;
  logic [1:0] lpDone, runDone;
  logic wrEn;
  logic [2:0] wrCore, wrAddr;
  logic [15:0] wrData;
  logic wrErr, tmoFlag, illFlag;
  logic [1:0] safeMode, appMode, chipMode, lpStart, runStart;
  logic [4:0] wakeIrq, errIrq;

  int checks = 0;
  int fails = 0;
  int lpCnt0 = 0, lpCnt1 = 0, runCnt0 = 0, runCnt1 = 0;

  always #2.5 clk = ~clk;

  dom_mode_ctrl u0 (
    .clk(clk), .rstN(rstN), .wfi(wfi), .wakeReq(wakeReq), .lpDone(lpDone),
    .runDone(runDone), .wrEn(wrEn), .wrCore(wrCore), .wrAddr(wrAddr),
    .wrData(wrData), .wrErr(wrErr), .safeMode(safeMode), .appMode(appMode),
    .chipMode(chipMode), .lpStart(lpStart), .runStart(runStart),
    .tmoFlag(tmoFlag), .illFlag(illFlag), .wakeIrq(wakeIrq), .errIrq(errIrq)
  );

  always @(negedge clk) begin
    if (lpStart[0])  lpCnt0++;
    if (lpStart[1])  lpCnt1++;
    if (runStart[0]) runCnt0++;
    if (runStart[1]) runCnt1++;
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic wr(input int core, input int addr, input int data, output logic err);
    wrEn = 1'b1; wrCore = core[2:0]; wrAddr = addr[2:0]; wrData = data[15:0];
    #1 err = wrErr;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic enterDom(input int d, input logic [4:0] m);
    wfi = wfi | m;
    @(negedge clk);
    lpDone[d] = 1'b1; wfi = wfi & ~m;
    @(negedge clk);
    lpDone[d] = 1'b0;
  endtask

  task automatic wakeDom(input int d, input int line);
    wakeReq[line] = 1'b1;
    @(negedge clk);
    wakeReq[line] = 1'b0; runDone[d] = 1'b1;
    @(negedge clk);
    runDone[d] = 1'b0;
  endtask

  task automatic tReset();
    chk("R1 safeMode", safeMode, 0);
    chk("R1 appMode", appMode, 0);
    chk("R1 chipMode", chipMode, 0);
    chk("R1 strobes", {lpStart, runStart}, 0);
    chk("R1 flags", {tmoFlag, illFlag}, 0);
    chk("R1 irqs", {wakeIrq, errIrq}, 0);
  endtask

  task automatic tEntryWake();
    logic e;
    wr(0, 6, 16'h0001, e);
    wr(0, 2, 16'h0001, e);
    wr(0, 0, 16'h0003, e);
    wfi[0] = 1'b1;
    @(negedge clk); #1;
    chk("R2 lpStart pulse", lpStart, 2'b01);
    chk("R2 mode RUN during entry", safeMode, 0);
    @(negedge clk); #1;
    chk("R2 lpStart one cycle", lpStart, 0);
    lpDone[0] = 1'b1; wfi[0] = 1'b0;
    @(negedge clk); #1;
    lpDone[0] = 1'b0;
    chk("R2 hibernate code", safeMode, 2);
    chk("R8 chip shallower", chipMode, 0);
    wakeReq[1] = 1'b1;
    @(negedge clk); #1;
    wakeReq[1] = 1'b0;
    @(negedge clk); #1;
    chk("R4 masked line ignored mode", safeMode, 2);
    chk("R4 masked line no runStart", runCnt0, 0);
    wakeReq[0] = 1'b1;
    @(negedge clk); #1;
    wakeReq[0] = 1'b0;
    chk("R4 runStart pulse", runStart, 2'b01);
    chk("R4 target held in exit", safeMode, 2);
    chk("R11 wake irq core0", wakeIrq, 5'b00001);
    runDone[0] = 1'b1;
    @(negedge clk); #1;
    runDone[0] = 1'b0;
    chk("R4 back to RUN", safeMode, 0);
    wr(1, 7, 16'h0001, e);
    #1 chk("R11 ack clears", wakeIrq, 0);
  endtask

  task automatic tBlocked();
    logic e;
    int base;
    base = lpCnt1;
    wr(1, 3, 16'h0002, e);
    wr(1, 1, 16'h0000, e);
    wfi = 5'b11110;
    repeat (3) @(negedge clk);
    #1 chk("R3 no entry when disabled", lpCnt1 - base, 0);
    wfi = 5'b01110;
    wr(1, 1, 16'h0001, e);
    repeat (3) @(negedge clk);
    #1 chk("R3 no entry with core missing WFI", lpCnt1 - base, 0);
    wfi = 5'b11110;
    @(negedge clk);
    lpDone[1] = 1'b1; wfi = 5'b00000;
    @(negedge clk);
    lpDone[1] = 1'b0;
    #1 chk("R3 entry once complete", lpCnt1 - base, 1);
    chk("R2 app sleep code", appMode, 1);
    chk("R8 chip shallower app", chipMode, 0);
    wakeDom(1, 1);
    #1 chk("R4 app back to RUN", appMode, 0);
  endtask

  task automatic tAbort();
    int rb;
    rb = runCnt0;
    wfi[0] = 1'b1;
    @(negedge clk);
    wakeReq[0] = 1'b1; wfi[0] = 1'b0;
    @(negedge clk);
    wakeReq[0] = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R5 abort to RUN", safeMode, 0);
    chk("R5 no runStart", runCnt0 - rb, 0);
    chk("R5 no illegal", illFlag, 0);
    chk("R5 no wake irq", wakeIrq, 0);
  endtask

  task automatic tTimeout();
    logic e;
    wr(0, 5, 16'h0004, e);
    wr(0, 6, 16'h0101, e);
    wfi[0] = 1'b1;
    @(negedge clk);
    wfi[0] = 1'b0;
    repeat (4) @(negedge clk);
    #1 chk("R6 no timeout yet", tmoFlag, 0);
    @(negedge clk); #1;
    chk("R6 timeout flag", tmoFlag, 1);
    chk("R6 back to RUN", safeMode, 0);
    chk("R12 err irq core0", errIrq, 5'b00001);
    wr(3, 7, 16'h4100, e);
    #1;
    chk("R12 tmo cleared", tmoFlag, 0);
    chk("R12 err irq cleared", errIrq, 0);
    wr(0, 5, 16'hFFFF, e);
  endtask

  task automatic tIllegal();
    logic e;
    runDone[0] = 1'b1;
    @(negedge clk); #1;
    runDone[0] = 1'b0;
    chk("R7 stray runDone flags", illFlag, 1);
    chk("R7 stray runDone keeps RUN", safeMode, 0);
    wr(0, 7, 16'h8100, e);
    #1 chk("R12 ill cleared", illFlag, 0);
    wr(0, 0, 16'h0005, e);
    enterDom(0, 5'b00001);
    #1 chk("R2 sleep code", safeMode, 1);
    lpDone[0] = 1'b1;
    @(negedge clk); #1;
    lpDone[0] = 1'b0;
    chk("R7 illegal wakes", runStart, 2'b01);
    chk("R7 ill flag", illFlag, 1);
    runDone[0] = 1'b1;
    @(negedge clk); #1;
    runDone[0] = 1'b0;
    chk("R7 back to RUN", safeMode, 0);
    wr(0, 7, 16'h8101, e);
  endtask

  task automatic tPolicy();
    logic e;
    wr(0, 4, 16'h0080, e);
    wr(1, 1, 16'h0001, e);
    wr(0, 0, 16'h0003, e);
    enterDom(1, 5'b11110);
    enterDom(0, 5'b00001);
    #1 chk("R8 chip is shallower", chipMode, 1);
    wr(0, 4, 16'h0081, e);
    #1 chk("R8 ignore app", chipMode, 2);
    wakeDom(0, 0);
    #1 chk("R8 ignore app after safe wake", chipMode, 0);
    wakeDom(1, 1);
    wr(1, 1, 16'h0000, e);
    wr(0, 4, 16'h0082, e);
    wfi[0] = 1'b1;
    @(negedge clk); #1;
    chk("R9 both enter together", lpStart, 2'b11);
    lpDone = 2'b11; wfi[0] = 1'b0;
    @(negedge clk); #1;
    lpDone = 2'b00;
    chk("R9 safe hib", safeMode, 2);
    chk("R9 app sleep", appMode, 1);
    wr(0, 4, 16'h0086, e);
    wakeReq[0] = 1'b1;
    @(negedge clk); #1;
    wakeReq[0] = 1'b0;
    chk("R10 both exit together", runStart, 2'b11);
    runDone = 2'b11;
    @(negedge clk); #1;
    runDone = 2'b00;
    chk("R10 both RUN", {safeMode, appMode}, 0);
    wr(0, 4, 16'h0080, e);
    wr(0, 7, 16'hC11F, e);
  endtask

  task automatic tPermission();
    logic e;
    int base;
    wr(0, 0, 16'h0000, e);
    wr(3, 0, 16'h0001, e);
    chk("R13 no error when reporting off", e, 0);
    base = lpCnt0;
    wfi[0] = 1'b1;
    repeat (3) @(negedge clk);
    wfi[0] = 1'b0;
    @(negedge clk); #1;
    chk("R13 foreign write dropped", lpCnt0 - base, 0);
    wr(0, 4, 16'h0088, e);
    wr(3, 0, 16'h0001, e);
    chk("R13 foreign write errors", e, 1);
    wr(0, 0, 16'h0000, e);
    chk("R13 primary write ok", e, 0);
    wr(0, 1, 16'h0000, e);
    chk("R13 safety core on app reg", e, 1);
    wr(4, 7, 16'h0000, e);
    chk("R13 clear reg open", e, 0);
    wr(0, 4, 16'h00A8, e);
    wr(0, 5, 16'hFFFF, e);
    chk("R13 old primary rejected", e, 1);
    wr(2, 5, 16'hFFFF, e);
    chk("R13 new primary accepted", e, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-requirements act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; wfi = '0; wakeReq = '0; lpDone = '0; runDone = '0;
    wrEn = 1'b0; wrCore = '0; wrAddr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    tReset();
    @(negedge clk);
    tEntryWake();
    tBlocked();
    tAbort();
    tTimeout();
    tIllegal();
    tPolicy();
    tPermission();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule